// File: doc/BRIEF.md
# Sparse Hit Row Buffer

This block sits beside one row of pixel discriminators and keeps only the parts of the row that saw a hit. An external strobe, aligned to the beam-crossing period, freezes the 42 asynchronous hit flags, the 13-bit timestamp and the override control. A scanner then inspects the row six pixels at a time, one group per clock. Each occupied group costs one memory entry, however many of its pixels fired, so a dense cluster uses few entries and a lone noise hit uses exactly one.

Entries are written in order through a one-hot write pointer into a 19-entry register memory. Each entry holds the timestamp, the group's 6-bit pattern and the 3-bit group index. Once the memory is full, further write attempts raise an overflow flag and are dropped, so the earliest entries survive. Stored entries leave through a valid/ready port in the order they were written, with a constant row identifier and a flag on the final entry. A clear input empties the memory and resets the flag. An override input forces one entry per group on every sample, which lets arbitrary timestamps and patterns exercise the write and read paths.

Top module: `hit_row_buffer`

## Requirements
- R1: A high `strobe_i` while `busy_o` is low captures `hits_i`, `tstamp_i` and `override_i`. Later changes on those inputs have no effect on the scan. `busy_o` is high for exactly 7 cycles after the capturing edge, and a strobe seen while `busy_o` is high is ignored.
- R2: The scanner visits groups 0 to 6 in ascending order, one per clock. Group g covers pixels 6g to 6g+5, and pattern bit 0 is pixel 6g.
- R3: A group with at least one hit is written as one entry {timestamp, 6-bit pattern, 3-bit binary group index}. A group with no hit writes nothing.
- R4: The memory holds 19 entries. A write attempt while all 19 are used sets `ovf_o`, the first 19 entries are kept, and later writes are dropped until a clear.
- R5: With the captured override bit set, every one of the 7 groups is written on that sample, including groups whose pattern is zero.
- R6: Readout presents entries in write order, each one once, over `rd_valid_o`/`rd_ready_i`. A presented word stays unchanged until it is accepted. `rd_row_o` always equals the `ROW_ID` parameter.
- R7: `rd_last_o` is high together with `rd_valid_o` exactly when the presented entry is the last valid one in memory.
- R8: `clear_i` empties the memory, resets the write and read pointers and clears `ovf_o`. A group write in the same cycle as a clear is lost, and writes after the clear start again at the first entry.
- R9: A read handshake and a group write in the same cycle both take effect, so the row can drain while it is still being scanned.
- R10: After reset, `busy_o`, `ovf_o` and `rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hits_i | input | 42 | Hit flag per pixel, bit n = pixel n |
| strobe_i | input | 1 | Sample strobe, one per bunch crossing |
| tstamp_i | input | 13 | Externally generated crossing timestamp |
| override_i | input | 1 | Store every group regardless of hits |
| clear_i | input | 1 | Empty the memory and reset the overflow flag |
| busy_o | output | 1 | Scan in progress, strobe not accepted |
| ovf_o | output | 1 | A write found the memory full |
| rd_valid_o | output | 1 | A stored entry is presented |
| rd_ready_i | input | 1 | Consumer accepts the presented entry |
| rd_last_o | output | 1 | Presented entry is the last one stored |
| rd_row_o | output | 8 | Constant row identifier |
| rd_tstamp_o | output | 13 | Timestamp of the presented entry |
| rd_pattern_o | output | 6 | Hit pattern of the presented entry |
| rd_group_o | output | 3 | Group index of the presented entry |

## Verification
A group write can land in the same clock as a read handshake, or in the same clock as a clear. The first case is provoked by holding `rd_ready_i` high through a full-row scan. Each entry is then taken one cycle after it is written, while the next group is being stored. All seven words must come out in group order with no loss or repeat. The second case pulses `clear_i` on exactly the edge that stores group 3 of a full row. The bench then expects that write to be lost and only groups 4 to 6 to be read out, starting again at the first entry.

// File: rtl/hrb_pkg.sv
// Shared constants and types for the sparse hit row buffer.
// Assumes: defaults describe a 42-pixel row split into six-pixel groups.
package hrb_pkg;
    localparam int HRB_NPIX  = 42;
    localparam int HRB_GRP_W = 6;
    localparam int HRB_TS_W  = 13;
    localparam int HRB_DEPTH = 19;

    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_SCAN = 1'b1
    } scan_state_t;
endpackage

// File: rtl/hrb_scanner.sv
// Captures the row on a strobe and walks it one group per clock, issuing a
// write request for each occupied group (or each group when override is set).
// Assumes: NPIX is a multiple of GRP_W; strobes during a scan are dropped.
module hrb_scanner
    import hrb_pkg::*;
#(
    parameter int NPIX  = HRB_NPIX,
    parameter int GRP_W = HRB_GRP_W,
    parameter int TS_W  = HRB_TS_W,
    localparam int NGRP  = NPIX / GRP_W,
    localparam int IDX_W = $clog2(NGRP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIX-1:0]  hits_i,
    input  logic             strobe_i,
    input  logic [TS_W-1:0]  tstamp_i,
    input  logic             override_i,
    output logic             busy_o,
    output logic             wr_en_o,
    output logic [TS_W-1:0]  wr_ts_o,
    output logic [GRP_W-1:0] wr_pat_o,
    output logic [IDX_W-1:0] wr_grp_o
);
    scan_state_t      state_q;
    logic [NPIX-1:0]  hold_q;
    logic [TS_W-1:0]  ts_q;
    logic             ovr_q;
    logic [IDX_W-1:0] grp_q;
    logic [GRP_W-1:0] grp_pat [NGRP];
    logic             scanning;

    // Slice the held row into its groups, bit 0 of each = lowest pixel.
    for (genvar g = 0; g < NGRP; g++) begin : g_slice
        assign grp_pat[g] = hold_q[g*GRP_W +: GRP_W];
    end

    assign scanning = (state_q == SC_SCAN);

    // Capture on an idle strobe, then step the group index to the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            hold_q  <= '0;
            ts_q    <= '0;
            ovr_q   <= 1'b0;
            grp_q   <= '0;
        end else if (!scanning) begin
            if (strobe_i) begin
                state_q <= SC_SCAN;
                hold_q  <= hits_i;
                ts_q    <= tstamp_i;
                ovr_q   <= override_i;
                grp_q   <= '0;
            end
        end else begin
            if (grp_q == IDX_W'(NGRP - 1)) begin
                state_q <= SC_IDLE;
                grp_q   <= '0;
            end else begin
                grp_q <= grp_q + 1'b1;
            end
        end
    end

    // Present the current group as a write request.
    always_comb begin
        wr_pat_o = grp_pat[grp_q];
        wr_ts_o  = ts_q;
        wr_grp_o = grp_q;
        wr_en_o  = scanning && ((|wr_pat_o) || ovr_q);
    end

    assign busy_o = scanning;

    // R2
    grp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> (grp_q < IDX_W'(NGRP)));
    // R1
    scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && grp_q == IDX_W'(NGRP - 1)) |=> !busy_o);
    // R1
    scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scanning && strobe_i) |=> (busy_o && grp_q == '0));
    // R2
    grp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && grp_q != IDX_W'(NGRP - 1)) |=> (grp_q == $past(grp_q) + 1'b1));
endmodule

// File: rtl/hrb_store.sv
// Entry memory with a one-hot write pointer, overflow flag and a one-hot
// read pointer that hands out valid entries in write order.
// Assumes: entries fill from the lowest slot; space returns only on clear.
module hrb_store #(
    parameter int DEPTH = 19,
    parameter int ENT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             wr_en_i,
    input  logic [ENT_W-1:0] wr_data_i,
    input  logic             rd_ready_i,
    output logic             rd_valid_o,
    output logic             rd_last_o,
    output logic [ENT_W-1:0] rd_data_o,
    output logic             ovf_o
);
    logic [DEPTH-1:0] wptr_q, rptr_q, valid_q;
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic             full, wr_ok, rd_fire;
    logic [DEPTH-1:0] sel;

    assign full    = ~|wptr_q;
    assign wr_ok   = wr_en_i && !full;
    assign sel     = rptr_q & valid_q;
    assign rd_valid_o = |sel;
    assign rd_last_o  = rd_valid_o && !(|((rptr_q << 1) & valid_q));
    assign rd_fire    = rd_valid_o && rd_ready_i;

    // Pointers, valid bits and overflow; clear takes priority over traffic.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            wptr_q  <= DEPTH'(1);
            rptr_q  <= DEPTH'(1);
            valid_q <= '0;
            ovf_o   <= 1'b0;
        end else begin
            if (wr_en_i && full) ovf_o <= 1'b1;
            if (wr_ok)   wptr_q <= wptr_q << 1;
            if (rd_fire) rptr_q <= rptr_q << 1;
            valid_q <= (valid_q | (wr_ok ? wptr_q : '0)) & ~(rd_fire ? rptr_q : '0);
        end
    end

    // One data register per slot, loaded when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_ok && wptr_q[i] && !clear_i) mem_q[i] <= wr_data_i;
        end
    end

    // AND-OR read mux over the selected valid slot.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel[i]) rd_data_o = rd_data_o | mem_q[i];
        end
    end

    // R4
    wptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wptr_q));
    // R6
    rptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rptr_q));
    // R4
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(wr_en_i && full));
    // R4
    stay_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clear_i) |=> (~|wptr_q));
    // R6
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i && !clear_i) |=> (rd_valid_o && $stable(rd_data_o)));
    // R8
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!ovf_o && !rd_valid_o));
endmodule

// File: rtl/hit_row_buffer.sv
// Sparse hit row buffer: group scanner feeding a one-hot entry memory with
// valid/ready readout tagged by a constant row identifier.
// Assumes: strobe is synchronous to clk; hits_i is stable around the strobe.
module hit_row_buffer
    import hrb_pkg::*;
#(
    parameter int          NPIX   = HRB_NPIX,
    parameter int          GRP_W  = HRB_GRP_W,
    parameter int          TS_W   = HRB_TS_W,
    parameter int          DEPTH  = HRB_DEPTH,
    parameter int          ROW_W  = 8,
    parameter logic [ROW_W-1:0] ROW_ID = 8'd5,
    localparam int NGRP  = NPIX / GRP_W,
    localparam int IDX_W = $clog2(NGRP),
    localparam int ENT_W = TS_W + GRP_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIX-1:0]  hits_i,
    input  logic             strobe_i,
    input  logic [TS_W-1:0]  tstamp_i,
    input  logic             override_i,
    input  logic             clear_i,
    output logic             busy_o,
    output logic             ovf_o,
    output logic             rd_valid_o,
    input  logic             rd_ready_i,
    output logic             rd_last_o,
    output logic [ROW_W-1:0] rd_row_o,
    output logic [TS_W-1:0]  rd_tstamp_o,
    output logic [GRP_W-1:0] rd_pattern_o,
    output logic [IDX_W-1:0] rd_group_o
);
    logic             wr_en;
    logic [TS_W-1:0]  wr_ts;
    logic [GRP_W-1:0] wr_pat;
    logic [IDX_W-1:0] wr_grp;
    logic [ENT_W-1:0] rd_data;

    hrb_scanner #(
        .NPIX  (NPIX),
        .GRP_W (GRP_W),
        .TS_W  (TS_W)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .hits_i     (hits_i),
        .strobe_i   (strobe_i),
        .tstamp_i   (tstamp_i),
        .override_i (override_i),
        .busy_o     (busy_o),
        .wr_en_o    (wr_en),
        .wr_ts_o    (wr_ts),
        .wr_pat_o   (wr_pat),
        .wr_grp_o   (wr_grp)
    );

    hrb_store #(
        .DEPTH (DEPTH),
        .ENT_W (ENT_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .wr_en_i    (wr_en),
        .wr_data_i  ({wr_ts, wr_pat, wr_grp}),
        .rd_ready_i (rd_ready_i),
        .rd_valid_o (rd_valid_o),
        .rd_last_o  (rd_last_o),
        .rd_data_o  (rd_data),
        .ovf_o      (ovf_o)
    );

    // Split the stored word into its fields and attach the row identifier.
    assign {rd_tstamp_o, rd_pattern_o, rd_group_o} = rd_data;
    assign rd_row_o = ROW_ID;

    // R3
    group_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (rd_group_o < IDX_W'(NGRP)));
endmodule

// File: tb/sim_hit_row_buffer.sv
module sim_hit_row_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [41:0] hits = '0;
    logic        strobe = 1'b0;
    logic [12:0] ts = '0;
    logic        ovr = 1'b0;
    logic        clear = 1'b0;
    logic        rd_ready = 1'b0;
    logic        busy, ovf, rd_valid, rd_last;
    logic [7:0]  rd_row;
    logic [12:0] rd_ts;
    logic [5:0]  rd_pat;
    logic [2:0]  rd_grp;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [12:0] exp_ts  [32];
    logic [5:0]  exp_pat [32];
    logic [2:0]  exp_grp [32];
    int          exp_n;
    bit          exp_ovf;

    localparam int NV = 6;
    localparam logic [41:0] VHITS [NV] = '{42'h1, 42'h200_0000_0000, 42'h60,
                                            42'h0, 42'h0, 42'h3FF_FFFF_FFFF};
    localparam logic [12:0] VTS   [NV] = '{13'h0123, 13'h1FFF, 13'h0A5A,
                                            13'h0777, 13'h0AAA, 13'h1234};
    localparam bit          VOVR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

    hit_row_buffer #(.ROW_ID(8'h2C)) u0 (
        .clk(clk), .rst_n(rst_n), .hits_i(hits), .strobe_i(strobe),
        .tstamp_i(ts), .override_i(ovr), .clear_i(clear), .busy_o(busy),
        .ovf_o(ovf), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
        .rd_last_o(rd_last), .rd_row_o(rd_row), .rd_tstamp_o(rd_ts),
        .rd_pattern_o(rd_pat), .rd_group_o(rd_grp)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        exp_n = 0;
        exp_ovf = 1'b0;
    endtask

    // Reference model of one sample: occupied groups (or all with override).
    task automatic model_sample(input logic [41:0] h, input logic [12:0] t, input bit o);
        for (int g = 0; g < 7; g++) begin
            logic [5:0] p;
            p = h[g*6 +: 6];
            if (p != 0 || o) begin
                if (exp_n < 19) begin
                    exp_ts[exp_n] = t; exp_pat[exp_n] = p; exp_grp[exp_n] = 3'(g);
                    exp_n++;
                end else begin
                    exp_ovf = 1'b1;
                end
            end
        end
    endtask

    task automatic sample(input logic [41:0] h, input logic [12:0] t, input bit o);
        @(negedge clk);
        hits = h; ts = t; ovr = o; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        hits = ~h; ts = ~t; ovr = ~o;
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    task automatic drain(input bit chk_last);
        int idx = 0;
        rd_ready = 1'b1;
        repeat (40) begin
            if (rd_valid) begin
                if (idx >= exp_n) begin
                    check(1'b0, "R6 extra word", rd_grp, 0);
                end else begin
                    check(rd_ts == exp_ts[idx] && rd_pat == exp_pat[idx] && rd_grp == exp_grp[idx],
                          "R3/R6 entry", {rd_ts, rd_pat, rd_grp}, {exp_ts[idx], exp_pat[idx], exp_grp[idx]});
                    check(rd_row == 8'h2C, "R6 row id", rd_row, 8'h2C);
                    if (chk_last)
                        check(rd_last == (idx == exp_n - 1), "R7 last flag", rd_last, idx == exp_n - 1);
                end
                idx++;
            end
            @(negedge clk);
        end
        rd_ready = 1'b0;
        check(idx == exp_n, "R6 word count", idx, exp_n);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_bad++; n_chk++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!busy && !ovf && !rd_valid, "R10 reset state", {busy, ovf, rd_valid}, 0);

        // Table of samples: R1 R2 R3 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            pulse_clear();
            model_reset();
            model_sample(VHITS[v], VTS[v], VOVR[v]);
            sample(VHITS[v], VTS[v], VOVR[v]);
            repeat (9) @(negedge clk);
            check(!busy, "R1 scan done", busy, 0);
            check(ovf == 1'b0, "R4 no overflow", ovf, 0);
            drain(1'b1);
        end

        // R6 back-pressure holds the word; R2 group order on a dense row
        pulse_clear();
        model_reset();
        model_sample(42'h3FF_FFFF_FFFF, 13'h0042, 1'b0);
        sample(42'h3FF_FFFF_FFFF, 13'h0042, 1'b0);
        repeat (9) @(negedge clk);
        repeat (4) @(negedge clk);
        check(rd_valid && rd_grp == 3'd0 && rd_ts == 13'h0042, "R6 hold under stall",
              {rd_valid, rd_grp}, {1'b1, 3'd0});
        drain(1'b1);

        // R1 strobe while busy is ignored
        pulse_clear();
        model_reset();
        model_sample(42'h1, 13'h0001, 1'b0);
        sample(42'h1, 13'h0001, 1'b0);
        @(negedge clk);
        check(busy, "R1 busy during scan", busy, 1);
        hits = 42'h3FF_FFFF_FFFF; ts = 13'h0002; ovr = 1'b0; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        repeat (9) @(negedge clk);
        drain(1'b1);

        // R4 overflow: 21 write attempts, first 19 kept
        pulse_clear();
        model_reset();
        for (int s = 0; s < 3; s++) begin
            model_sample(42'h3FF_FFFF_FFFF, 13'(16 + s), 1'b0);
            sample(42'h3FF_FFFF_FFFF, 13'(16 + s), 1'b0);
            repeat (9) @(negedge clk);
        end
        check(ovf == exp_ovf && exp_ovf, "R4 overflow flag", ovf, exp_ovf);
        drain(1'b1);
        check(ovf, "R4 flag sticky after readout", ovf, 1);

        // R8 clear on the edge that stores group 3
        model_reset();
        sample(42'h3FF_FFFF_FFFF, 13'h0099, 1'b0);
        repeat (3) @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check(!ovf, "R8 overflow cleared", ovf, 0);
        for (int g = 4; g < 7; g++) begin
            exp_ts[exp_n] = 13'h0099; exp_pat[exp_n] = 6'h3F; exp_grp[exp_n] = 3'(g); exp_n++;
        end
        repeat (6) @(negedge clk);
        drain(1'b1);

        // R9 read handshakes concurrent with group writes
        pulse_clear();
        model_reset();
        model_sample(42'h3F0_4001_8C21, 13'h0ABC, 1'b0);
        rd_ready = 1'b1;
        sample(42'h3F0_4001_8C21, 13'h0ABC, 1'b0);
        drain(1'b0);
        check(!rd_valid, "R9 drained during scan", rd_valid, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule